// File: doc/BRIEF.md
# Multiplexed-Bus Auto-Increment Peripheral Port

This block is the peripheral side of a narrow bus on which one set of eight bidirectional lines carries both address bytes and data bytes, one after the other. The bus master loads a 16-bit address with two separate strobes: one for the low byte and one for the high byte. After that it issues only read or write data strobes. The port keeps its own copy of the address and advances it after every data transfer. A burst of sequential accesses therefore costs one address setup and then one strobe per byte.

Behind the port is a small byte memory that answers a window of the 16-bit address space. The window starts at a base address and may wrap past 0xFFFF into 0x0000. During a read strobe the port drives the bus only when the address falls inside that window. At all other times the bus lines are left high-impedance, and a drive-enable output shows which way the pad is turned. All strobes are sampled in the system clock domain. Each strobe acts once, at its detected rising edge.

Top module: `mux_bus_port`

## Requirements
- R1: After reset the stored address is 0x0000, the memory holds 0x00 in every byte, and the port does not drive the bus.
- R2: A rising edge on the low-address strobe loads the bus byte into address bits 7:0 and leaves bits 15:8 unchanged.
- R3: A rising edge on the high-address strobe loads the bus byte into address bits 15:8 and leaves bits 7:0 unchanged.
- R4: A rising edge on the write strobe stores the bus byte at the current address if that address is in the window, and then adds one to the address.
- R5: A rising edge on the read strobe fetches the byte at the current address and adds one to the address. From the clock edge that detects the strobe until the strobe falls, the port drives that byte on the bus and holds drive_o at 1.
- R6: A strobe held high for several cycles acts only once. The next transfer needs a new rising edge.
- R7: The address counter wraps from 0xFFFF to 0x0000.
- R8: The window is the range of addresses a with (a - BASE_ADDR) mod 2^16 < MEM_DEPTH (0xFFE0 to 0x001F by default). Outside the window a read does not drive the bus and a write changes no memory byte. The address still advances in both cases.
- R9: An address strobe that arrives between data strobes replaces the incremented address. Later increments continue from the newly loaded value.
- R10: If an address strobe rises in the same cycle as a data strobe, only the address is loaded. There is no transfer and no increment. If read and write strobes rise together, only the write takes place.
- R11: While the read strobe is low, drive_o is 0 and the bus is high-impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_io | inout | 8 | Shared address/data lines |
| addr_lo_stb_i | input | 1 | Load low address byte strobe |
| addr_hi_stb_i | input | 1 | Load high address byte strobe |
| rd_stb_i | input | 1 | Read data strobe |
| wr_stb_i | input | 1 | Write data strobe |
| drive_o | output | 1 | High while the port drives bus_io |

## Verification
A wrong stored address shows up only through data: the next read returns a byte from the wrong location, or the next write lands where a later read finds it. The bench therefore follows every address change, including increments, wraps, partial loads and overrides, with a read-back on the following strobe. A stuck or repeated increment appears within one or two strobes. A drive-enable fault shows at once on drive_o in the same cycle that the read strobe rises or falls. A write that lands outside the window shows up later, as a non-zero byte at the aliased location.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int unsigned NUM_STB = 4;
  localparam int unsigned STB_ALO = 0;
  localparam int unsigned STB_AHI = 1;
  localparam int unsigned STB_RD  = 2;
  localparam int unsigned STB_WR  = 3;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } xfer_op_e;
endpackage

// File: rtl/mbp_strobe_edge.sv
module mbp_strobe_edge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= lvl_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];

    assert_rise_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[i] |=> !rise_o[i]);
  end
endmodule

// File: rtl/mbp_addr_ctr.sv
module mbp_addr_ctr #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_ld_i,
  input  logic              hi_ld_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (lo_ld_i) addr_d[DATA_W-1:0] = din_i;
    if (hi_ld_i) addr_d[ADDR_W-1:DATA_W] = din_i;
    if (step_i && !lo_ld_i && !hi_ld_i) addr_d = addr_q + 1'b1; // wraps naturally
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  assert_lo_keeps_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ld_i && !hi_ld_i) |=> addr_q[ADDR_W-1:DATA_W] == $past(addr_q[ADDR_W-1:DATA_W]));

  assert_hi_keeps_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_ld_i && !lo_ld_i) |=> addr_q[DATA_W-1:0] == $past(addr_q[DATA_W-1:0]));

  assert_step_wraps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !lo_ld_i && !hi_ld_i && (&addr_q)) |=> addr_q == '0);
endmodule

// File: rtl/mbp_byte_mem.sv
module mbp_byte_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned MEM_DEPTH = 64,
  parameter logic [2*DATA_W-1:0] BASE_ADDR = 16'hFFE0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  inout  wire  [DATA_W-1:0] bus_io,
  input  logic              addr_lo_stb_i,
  input  logic              addr_hi_stb_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  output logic              drive_o
);
  import mbp_pkg::*;

  localparam int unsigned ADDR_W = 2 * DATA_W;
  localparam int unsigned IDX_W  = $clog2(MEM_DEPTH);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(MEM_DEPTH);

  logic [NUM_STB-1:0] stb_lvl, stb_rise;
  logic               addr_ld;
  xfer_op_e           op;
  logic [ADDR_W-1:0]  addr, off;
  logic               hit, mem_we;
  logic [DATA_W-1:0]  mem_rdata, rdata_q;
  logic               rd_act_q;

  always_comb begin
    stb_lvl          = '0;
    stb_lvl[STB_ALO] = addr_lo_stb_i;
    stb_lvl[STB_AHI] = addr_hi_stb_i;
    stb_lvl[STB_RD]  = rd_stb_i;
    stb_lvl[STB_WR]  = wr_stb_i;
  end

  mbp_strobe_edge #(.N(NUM_STB)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (stb_lvl),
    .rise_o (stb_rise)
  );

  // address strobes beat data strobes; write beats read
  assign addr_ld = stb_rise[STB_ALO] | stb_rise[STB_AHI];
  always_comb begin
    op = OP_NONE;
    if (!addr_ld) begin
      if (stb_rise[STB_WR])      op = OP_WRITE;
      else if (stb_rise[STB_RD]) op = OP_READ;
    end
  end

  mbp_addr_ctr #(.DATA_W(DATA_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lo_ld_i (stb_rise[STB_ALO]),
    .hi_ld_i (stb_rise[STB_AHI]),
    .step_i  (op != OP_NONE),
    .din_i   (bus_io),
    .addr_o  (addr)
  );

  assign off    = addr - BASE_ADDR;
  assign hit    = off < DEPTH_A;
  assign mem_we = (op == OP_WRITE) && hit;

  mbp_byte_mem #(.DATA_W(DATA_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .idx_i   (off[IDX_W-1:0]),
    .wdata_i (bus_io),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rd_act_q <= 1'b0;
    end else if (op == OP_READ) begin
      rdata_q  <= mem_rdata;
      rd_act_q <= hit;
    end else if (!rd_stb_i) begin
      rd_act_q <= 1'b0;
    end
  end

  assign drive_o = rd_stb_i & rd_act_q;
  assign bus_io  = drive_o ? rdata_q : 'z;

  assert_addr_ld_blocks_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ld |-> !mem_we);

  assert_read_steps_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_READ) |=> addr == $past(addr) + 1'b1);

  assert_drive_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_o && $past(drive_o)) |-> $stable(rdata_q));

  assert_drive_from_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op == OP_READ) && !hit) |=> !drive_o);
endmodule

// File: tb/mux_bus_port_bench.sv
module mux_bus_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic alo = 0, ahi = 0, rd = 0, wr = 0;
  logic [7:0] drv = '0;
  logic drv_en = 0;
  wire  [7:0] bus;
  wire        drive;
  assign bus = drv_en ? drv : 8'hzz;

  mux_bus_port u_mux_bus_port (
    .clk_i(clk), .rst_ni(rst_n), .bus_io(bus),
    .addr_lo_stb_i(alo), .addr_hi_stb_i(ahi),
    .rd_stb_i(rd), .wr_stb_i(wr), .drive_o(drive)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0]  model [64];
  logic [15:0] m_addr = 16'h0000;

  function automatic logic in_win(input logic [15:0] a);
    logic [15:0] o;
    o = a - 16'hFFE0;
    return o < 16'd64;
  endfunction

  function automatic int idx(input logic [15:0] a);
    logic [15:0] o;
    o = a - 16'hFFE0;
    return int'(o[5:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_lo(input logic [7:0] b);
    @(negedge clk); drv = b; drv_en = 1; alo = 1;
    @(negedge clk); alo = 0; drv_en = 0;
    m_addr[7:0] = b;
  endtask

  task automatic load_hi(input logic [7:0] b);
    @(negedge clk); drv = b; drv_en = 1; ahi = 1;
    @(negedge clk); ahi = 0; drv_en = 0;
    m_addr[15:8] = b;
  endtask

  task automatic set_addr(input logic [15:0] a);
    load_hi(a[15:8]);
    load_lo(a[7:0]);
  endtask

  task automatic wr_byte(input logic [7:0] b, input int hold);
    @(negedge clk); drv = b; drv_en = 1; wr = 1;
    repeat (hold) @(negedge clk);
    wr = 0; drv_en = 0;
    if (in_win(m_addr)) model[idx(m_addr)] = b;
    m_addr = m_addr + 16'd1;
  endtask

  task automatic rd_chk(input string tag, input int hold);
    logic [7:0] exp;
    logic       win;
    win = in_win(m_addr);
    exp = model[idx(m_addr)];
    @(negedge clk); rd = 1;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(drive == win, {tag, " drive"}, 16'(drive), 16'(win));
      if (win) chk(bus == exp, {tag, " data"}, 16'(bus), 16'(exp));
    end
    rd = 0;
    #1;
    chk(drive == 1'b0, "R11 release", 16'(drive), 16'd0);
    m_addr = m_addr + 16'd1;
  endtask

  task automatic t_reset();
    chk(drive == 1'b0, "R1 idle drive", 16'(drive), 16'd0);
    rd_chk("R1 read at 0000", 1);
  endtask

  task automatic t_burst();
    set_addr(16'hFFE0);
    for (int i = 0; i < 4; i++) wr_byte(8'hA0 + 8'(i), 1);
    set_addr(16'hFFE0);
    for (int i = 0; i < 4; i++) rd_chk("R4 R5 burst", 1);
  endtask

  task automatic t_partial();
    set_addr(16'h0010);
    for (int i = 0; i < 4; i++) wr_byte(8'h30 + 8'(i), 1);
    set_addr(16'hFFF3);
    wr_byte(8'h5C, 1);
    set_addr(16'h0010);
    load_lo(8'h12);
    rd_chk("R2 low only", 1);
    load_hi(8'hFF);
    rd_chk("R3 high only", 1);
  endtask

  task automatic t_wrap();
    set_addr(16'hFFFF);
    wr_byte(8'h11, 1);
    wr_byte(8'h22, 1);
    set_addr(16'h0000);
    rd_chk("R7 after wrap", 1);
    set_addr(16'hFFFF);
    rd_chk("R7 at top", 1);
    rd_chk("R7 read wrap", 1);
  endtask

  task automatic t_held();
    set_addr(16'hFFE8);
    wr_byte(8'h77, 3);
    wr_byte(8'h88, 1);
    set_addr(16'hFFE8);
    rd_chk("R6 held read", 3);
    rd_chk("R6 next", 1);
  endtask

  task automatic t_window();
    set_addr(16'hFFDF);
    wr_byte(8'h99, 1);
    wr_byte(8'h42, 1);
    set_addr(16'hFFDF);
    rd_chk("R8 below window", 2);
    rd_chk("R8 first in window", 1);
    set_addr(16'h001F);
    rd_chk("R8 alias untouched", 1);
    rd_chk("R8 above window", 1);
  endtask

  task automatic t_override();
    set_addr(16'hFFE0);
    rd_chk("R9 before", 1);
    load_lo(8'hE2);
    rd_chk("R9 override", 1);
    rd_chk("R9 continue", 1);
  endtask

  task automatic t_priority();
    set_addr(16'hFFE0);
    @(negedge clk); drv = 8'hE1; drv_en = 1; alo = 1; wr = 1;
    @(negedge clk); alo = 0; wr = 0; drv_en = 0;
    m_addr[7:0] = 8'hE1;
    rd_chk("R10 addr beats write", 1);
    set_addr(16'hFFE5);
    @(negedge clk); drv = 8'h6B; drv_en = 1; rd = 1; wr = 1;
    @(negedge clk);
    chk(drive == 1'b0, "R10 write beats read", 16'(drive), 16'd0);
    rd = 0; wr = 0; drv_en = 0;
    model[idx(m_addr)] = 8'h6B;
    m_addr = m_addr + 16'd1;
    set_addr(16'hFFE5);
    rd_chk("R10 written byte", 1);
    rd_chk("R10 single step", 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_burst();
    t_partial();
    t_wrap();
    t_held();
    t_window();
    t_override();
    t_priority();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule